// File: doc/BRIEF.md
# Clamped Duty-Cycle PWM Generator

This block turns an unsigned duty command into a single-bit pulse-width-modulated output at a fixed frame rate. The frame length is a parameter counted in system-clock cycles. A free-running frame counter marks each frame boundary. On that boundary the block takes one sample of the command, scales it to a pulse width in cycles, and holds that width for the whole frame. The output rises at every boundary and falls once the held width has elapsed.

The scaled width is bounded at both ends: it is never below about 1% of the frame and never above about 99%. Because of this, the output makes a rising and a falling transition in every frame, whatever the command. A one-cycle strobe marks each boundary so that downstream logic can align to the frames. The command is a level input and is not a stream. The block only samples it, so there is no handshake and nothing to back-pressure.

Top module: `pwm_clamp_gen`

## Requirements
- R1: The duty command is sampled only on the clock edge that opens a frame. A change to the command at any other time leaves the current frame's pulse width unchanged.
- R2: In the first cycle of every frame, pwm_out is high and frame_start is high.
- R3: Inside the clamp window, the high time of a frame is floor(cmd * PERIOD / (2^CMD_W - 1)) cycles. Full scale, all ones, means 100%.
- R4: When that product is smaller than the lower limit, the high time equals the lower limit. The lower limit is ceil(PERIOD/100), and never less than 1 cycle.
- R5: When that product is larger than the upper limit, the high time equals the upper limit. The upper limit is floor(99*PERIOD/100), and never more than PERIOD-1 cycles. As a result, pwm_out is low in the last cycle of every frame.
- R6: Frames are exactly PERIOD cycles long. frame_start is high for exactly one cycle per frame.
- R7: While rst (synchronous, active high) is asserted, pwm_out and frame_start are low. The first clock edge with rst low opens a new frame at counter zero.
- R8: Within a frame, the high cycles come first and form one contiguous run, followed by low cycles until the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_cmd | input | CMD_W | Unsigned duty command; all ones means full scale |
| pwm_out | output | 1 | PWM output, registered |
| frame_start | output | 1 | One-cycle strobe in the first cycle of each frame |

## Verification
On every cycle the assertions check these properties:
- the counter wraps cleanly from PERIOD-1 to zero;
- the held width stays inside the clamp window;
- the held width changes only at a frame load;
- the strobe never appears without the output being high;
- the output is low in the closing cycle of each frame;
- reset clears both outputs.

Only the bench scenarios can show the rest. It measures the exact high time of each frame against the scaling and clamp rules, using both directed commands at the clamp edges and random ones. It checks that commands scrambled in the middle of a frame are ignored. It checks that the pulse is a single contiguous run. It checks that a reset in the middle of a frame restarts the frame counting from zero.

// File: rtl/pwm_clamp_pkg.sv
package pwm_clamp_pkg;

  // Smallest permitted pulse width in cycles: ceil(period/100), at least 1.
  function automatic int unsigned lo_limit(input int unsigned period);
    int unsigned v;
    v = (period + 99) / 100;
    if (v < 1) v = 1;
    return v;
  endfunction

  // Largest permitted pulse width in cycles: floor(99*period/100), at most period-1.
  function automatic int unsigned hi_limit(input int unsigned period);
    int unsigned v;
    v = (99 * period) / 100;
    if (v > period - 1) v = period - 1;
    return v;
  endfunction

endpackage

// File: rtl/pwm_frame_counter.sv
module pwm_frame_counter #(
  parameter int unsigned PERIOD = 100,
  localparam int unsigned CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic             frame_load
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt        = cnt_q;
  assign frame_load = (cnt_q == '0);

  // R6: counter stays inside the frame and wraps back to zero
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  p_cnt_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LAST) |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_duty_scaler.sv
module pwm_duty_scaler
  import pwm_clamp_pkg::*;
#(
  parameter int unsigned PERIOD = 100,
  parameter int unsigned CMD_W  = 8,
  localparam int unsigned CNT_W  = $clog2(PERIOD),
  localparam int unsigned PROD_W = CMD_W + CNT_W + 1
) (
  input  logic [CMD_W-1:0] cmd,
  output logic [CNT_W-1:0] width
);

  localparam int unsigned FULL = (1 << CMD_W) - 1;
  localparam int unsigned LO_W = lo_limit(PERIOD);
  localparam int unsigned HI_W = hi_limit(PERIOD);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] raw;

  always_comb begin
    prod = PROD_W'(cmd) * PROD_W'(PERIOD);
    raw  = prod / PROD_W'(FULL);
    if (raw < PROD_W'(LO_W))      width = CNT_W'(LO_W);
    else if (raw > PROD_W'(HI_W)) width = CNT_W'(HI_W);
    else                          width = CNT_W'(raw);
  end

endmodule

// File: rtl/pwm_output_stage.sv
module pwm_output_stage
  import pwm_clamp_pkg::*;
#(
  parameter int unsigned PERIOD = 100,
  localparam int unsigned CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_load,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] width_in,
  output logic             pwm,
  output logic             strobe
);

  localparam int unsigned LO_W = lo_limit(PERIOD);
  localparam int unsigned HI_W = hi_limit(PERIOD);

  logic [CNT_W-1:0] width_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q <= CNT_W'(LO_W);
      pwm     <= 1'b0;
      strobe  <= 1'b0;
    end else if (frame_load) begin
      width_q <= width_in;
      pwm     <= 1'b1;
      strobe  <= 1'b1;
    end else begin
      pwm     <= (cnt < width_q);
      strobe  <= 1'b0;
    end
  end

  // R4/R5: held width never leaves the clamp window
  p_width_window_r4: assert property (@(posedge clk) disable iff (rst)
    (width_q >= CNT_W'(LO_W)) && (width_q <= CNT_W'(HI_W)));
  // R1: held width only moves on a frame load
  p_width_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !frame_load |=> $stable(width_q));
  // R2: strobe always coincides with a high output
  p_strobe_high_r2: assert property (@(posedge clk) disable iff (rst)
    strobe |-> pwm);

endmodule

// File: rtl/pwm_clamp_gen.sv
module pwm_clamp_gen #(
  parameter int unsigned PERIOD = 100,
  parameter int unsigned CMD_W  = 8,
  localparam int unsigned CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] duty_cmd,
  output logic             pwm_out,
  output logic             frame_start
);

  logic [CNT_W-1:0] cnt;
  logic             frame_load;
  logic [CNT_W-1:0] width;

  pwm_frame_counter #(.PERIOD(PERIOD)) u_cnt (
    .clk(clk), .rst(rst), .cnt(cnt), .frame_load(frame_load)
  );

  pwm_duty_scaler #(.PERIOD(PERIOD), .CMD_W(CMD_W)) u_scale (
    .cmd(duty_cmd), .width(width)
  );

  pwm_output_stage #(.PERIOD(PERIOD)) u_out (
    .clk(clk), .rst(rst), .frame_load(frame_load), .cnt(cnt),
    .width_in(width), .pwm(pwm_out), .strobe(frame_start)
  );

  // R5: output is low in the closing cycle of every frame
  p_low_at_close_r5: assert property (@(posedge clk) disable iff (rst)
    frame_load |-> !pwm_out);
  // R7: reset clears both outputs on the following cycle
  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (!pwm_out && !frame_start));

endmodule

// File: tb/sim_pwm_clamp_gen.sv
module sim_pwm_clamp_gen;

  localparam int unsigned PERIOD = 100;
  localparam int unsigned CMD_W  = 8;
  localparam int unsigned FULL   = (1 << CMD_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CMD_W-1:0] duty_cmd = '0;
  logic             pwm_out;
  logic             frame_start;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_clamp_gen #(.PERIOD(PERIOD), .CMD_W(CMD_W)) u0 (
    .clk(clk), .rst(rst), .duty_cmd(duty_cmd),
    .pwm_out(pwm_out), .frame_start(frame_start)
  );

  function automatic int lo_w();
    int v;
    v = (PERIOD + 99) / 100;
    if (v < 1) v = 1;
    return v;
  endfunction

  function automatic int hi_w();
    int v;
    v = (99 * PERIOD) / 100;
    if (v > PERIOD - 1) v = PERIOD - 1;
    return v;
  endfunction

  function automatic int exp_width(input int c);
    int w;
    w = (c * PERIOD) / FULL;
    if (w < lo_w()) w = lo_w();
    if (w > hi_w()) w = hi_w();
    return w;
  endfunction

  function automatic string width_tag(input int c);
    int w;
    w = (c * PERIOD) / FULL;
    if (w < lo_w()) return "R4";
    if (w > hi_w()) return "R5";
    return "R3";
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a negedge just before a frame boundary.
  task automatic run_frame(input int c, input bit scramble);
    int w, high, extra_fs;
    bit seen_low, contig;
    duty_cmd = CMD_W'(c);
    w = exp_width(c);
    @(posedge clk); @(negedge clk);
    check(frame_start == 1'b1, "R6 strobe at boundary", int'(frame_start), 1);
    check(pwm_out == 1'b1, "R2 high at frame open", int'(pwm_out), 1);
    high = 1; extra_fs = 0; seen_low = 0; contig = 1;
    for (int i = 1; i < int'(PERIOD); i++) begin
      if (scramble) duty_cmd = CMD_W'($urandom_range(0, FULL));
      @(posedge clk); @(negedge clk);
      if (frame_start) extra_fs++;
      if (pwm_out) begin
        high++;
        if (seen_low) contig = 0;
      end else seen_low = 1;
    end
    if (scramble) check(high == w, "R1 mid-frame change ignored", high, w);
    else          check(high == w, width_tag(c), high, w);
    check(contig, "R8 single contiguous pulse", int'(contig), 1);
    check(extra_fs == 0, "R6 one strobe per frame", extra_fs, 0);
    check(pwm_out == 1'b0, "R5 low in closing cycle", int'(pwm_out), 0);
  endtask

  initial begin
    int dir [16] = '{0, 1, 2, 3, 4, 5, 6, 64, 128, 200, 250, 252, 253, 254, 255, 127};
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pwm_out == 1'b0, "R7 reset pwm low", int'(pwm_out), 0);
    check(frame_start == 1'b0, "R7 reset strobe low", int'(frame_start), 0);
    rst = 1'b0;
    foreach (dir[k]) run_frame(dir[k], 1'b0);
    run_frame(255, 1'b1);
    run_frame(0, 1'b1);
    run_frame(100, 1'b1);
    for (int k = 0; k < 30; k++)
      run_frame(int'($urandom_range(0, FULL)), bit'($urandom_range(0, 1)));
    // reset in the middle of a high pulse
    duty_cmd = CMD_W'(255);
    repeat (10) begin @(posedge clk); @(negedge clk); end
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(pwm_out == 1'b0, "R7 mid-frame reset pwm low", int'(pwm_out), 0);
    check(frame_start == 1'b0, "R7 mid-frame reset strobe low", int'(frame_start), 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    run_frame(128, 1'b0);
    run_frame(3, 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule